// File: doc/BRIEF.md
# Word-Rate Conversion Sequencer

This block paces conversions for a slow-clocked measurement converter. It runs from the master clock, nominally 32.768 kHz. A 3-bit rate code picks the conversion period from a fixed table of master-clock counts. A command decoder upstream issues one-cycle strobes that start either one conversion or an endless series. When a period expires, the block captures the word on `data_in` into the result register. It raises a one-cycle end-of-conversion pulse and sets a sticky done flag. A level on `power_save` halts all activity and holds the block in a sleep state.

The done flag is cleared in one of two ways. The host can read the conversion-data register, which is signalled by `read_strobe`. The host can also use the ready-line handshake. With `pflag_mode` set, the serial output line `sdo` idles high and falls low once a result is waiting. The host then gives eight serial clocks to acknowledge, which clears the flag. The next twenty-four serial clocks shift the captured result out most significant bit first. Serial clock edges reach the block as synchronous one-cycle strobes on `sclk_pulse`.

The sequencer machine has four states. SQ_IDLE waits for a start. SQ_FIRST times the first conversion after a start, which is the period plus a 7-cycle penalty. SQ_REPEAT times each later continuous conversion at exactly the period. SQ_SLEEP is held while power-save is asserted. Its transitions are:
- start: SQ_IDLE, SQ_FIRST or SQ_REPEAT to SQ_FIRST.
- single done: SQ_FIRST or SQ_REPEAT to SQ_IDLE.
- continue: SQ_FIRST or SQ_REPEAT to SQ_REPEAT.
- sleep: any state to SQ_SLEEP.
- wake: SQ_SLEEP to SQ_IDLE.

The ready-line port machine has three states. SP_IDLE drives the ready level. SP_FLAG counts the eight acknowledge clocks. SP_SHIFT sends the result bits. Its transitions are ack begin (SP_IDLE to SP_FLAG), ack end (SP_FLAG to SP_SHIFT) and word end (SP_SHIFT to SP_IDLE).

Top module: `wordrate_conv_seq`

## Requirements
- R1: A start strobe sampled at clock edge E0 produces the first completion at edge E0+P+7. P is set by `rate_code`: 0→2182, 1→1090, 2→546, 3→266, 4→194, 5→162, 6→8722, 7→4362.
- R2: After `start_cont`, each completion following the first comes exactly P cycles after the previous one, until a stop.
- R3: After `start_single`, exactly one completion occurs, and then the block returns to idle. When both start strobes arrive in the same cycle, continuous mode wins.
- R4: At each completion, `result` takes the value of `data_in` sampled at that edge. `eoc` is high for exactly one cycle, and `done_flag` is set.
- R5: `read_strobe` clears `done_flag` at the next edge unless a completion happens at that same edge, in which case the flag stays set. A completion while the flag is already set overwrites `result` and leaves the flag set.
- R6: A start strobe arriving during a conversion abandons that conversion and times a new first conversion of P+7 cycles from the new strobe.
- R7: While `power_save` is high, no completion occurs. Start strobes are ignored, and `result` and `done_flag` hold. After release, the block is idle and waits for a new start.
- R8: With `pflag_mode` high and no serial transfer in progress, `sdo` is low while `done_flag` is set and high otherwise. With `pflag_mode` low, `sdo` stays high.
- R9: In ready-line mode, the 8th `sclk_pulse` clears `done_flag` and places result bit 23 on `sdo`. Each following pulse moves to the next lower bit down to bit 0. The pulse after bit 0 returns `sdo` to the ready level.
- R10: After reset, `eoc` and `done_flag` are 0, `result` is 0, `sdo` is 1, and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code | input | 3 | Word-rate code selecting the period |
| start_single | input | 1 | One-cycle strobe: perform one conversion |
| start_cont | input | 1 | One-cycle strobe: convert continuously |
| power_save | input | 1 | Level: stop and sleep |
| read_strobe | input | 1 | One-cycle strobe: conversion-data register read, clears the done flag |
| pflag_mode | input | 1 | Enables the ready-line mode on `sdo` |
| sclk_pulse | input | 1 | One-cycle strobe per serial clock |
| data_in | input | RES_W | Stub result word captured at completion |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| done_flag | output | 1 | Sticky completion flag |
| result | output | RES_W | Last captured result |
| sdo | output | 1 | Serial data / ready line |

## Verification
Every rate code is timed in both single and continuous modes. Swapping two table entries, or dropping or misplacing the 7-cycle penalty, shifts a measured count away from P+7 or P. A start arriving mid-conversion is checked for a full reload; a design that kept counting would finish about 50 cycles early. The bench lines up a read with a completion in the same cycle, so a design that lets the clear win loses a fresh result. It also holds power-save across several periods with start strobes applied, which exposes a leaking counter or an accepted start. The ready-line transfer is followed bit by bit, so an off-by-one in the acknowledge count or the bit order shows up as a wrong `sdo` value at a known clock.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    localparam int unsigned WRC_MAX_PERIOD = 8722;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FIRST,
        SQ_REPEAT,
        SQ_SLEEP
    } sq_state_t;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_FLAG,
        SP_SHIFT
    } sp_state_t;

    // Conversion period in master-clock cycles for each rate code.
    function automatic int unsigned wrc_period(input logic [2:0] code);
        int unsigned p;
        unique case (code)
            3'd0: p = 2182;
            3'd1: p = 1090;
            3'd2: p = 546;
            3'd3: p = 266;
            3'd4: p = 194;
            3'd5: p = 162;
            3'd6: p = 8722;
            3'd7: p = 4362;
            default: p = 2182;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/wrc_period_sel.sv
module wrc_period_sel
    import wrc_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int PENALTY = 7
) (
    input  logic [2:0]       rate_code,
    output logic [CNT_W-1:0] first_load,
    output logic [CNT_W-1:0] repeat_load
);
    // Loads are period-1 because the completion is taken on the zero count.
    always_comb begin
        int unsigned p;
        p           = wrc_period(rate_code);
        first_load  = CNT_W'(p + PENALTY - 1);
        repeat_load = CNT_W'(p - 1);
    end
endmodule

// File: rtl/wrc_down_timer.sv
module wrc_down_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign at_zero = (cnt == '0);
endmodule

// File: rtl/wrc_flag_port.sv
module wrc_flag_port
    import wrc_pkg::*;
#(
    parameter int RES_W     = 24,
    parameter int FLAG_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pflag_mode,
    input  logic             done_flag,
    input  logic [RES_W-1:0] result,
    input  logic             sclk_pulse,
    output logic             sdo,
    output logic             flag_clr,
    output logic             port_idle
);
    localparam int FCW = $clog2(FLAG_CLKS);
    localparam int BCW = $clog2(RES_W);

    sp_state_t        st, st_nxt;
    logic [FCW-1:0]   fcnt;
    logic [BCW-1:0]   bcnt;
    logic [RES_W-1:0] shreg;
    logic             ack_last, word_last;

    assign ack_last  = (fcnt == FCW'(FLAG_CLKS - 1));
    assign word_last = (bcnt == BCW'(RES_W - 1));

    always_comb begin
        st_nxt = st;
        unique case (st)
            SP_IDLE:  if (pflag_mode && done_flag && sclk_pulse) st_nxt = SP_FLAG;
            SP_FLAG:  if (sclk_pulse && ack_last)                st_nxt = SP_SHIFT;
            SP_SHIFT: if (sclk_pulse && word_last)               st_nxt = SP_IDLE;
            default:                                             st_nxt = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SP_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
        end else begin
            unique case (st)
                SP_IDLE: begin
                    fcnt <= FCW'(1);
                    bcnt <= '0;
                end
                SP_FLAG: begin
                    if (sclk_pulse) begin
                        if (ack_last) shreg <= result;
                        else          fcnt  <= fcnt + 1'b1;
                    end
                end
                SP_SHIFT: begin
                    if (sclk_pulse && !word_last) begin
                        bcnt  <= bcnt + 1'b1;
                        shreg <= {shreg[RES_W-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    assign flag_clr  = (st == SP_FLAG) && sclk_pulse && ack_last;
    assign port_idle = (st == SP_IDLE);

    always_comb begin
        unique case (st)
            SP_IDLE:  sdo = !(pflag_mode && done_flag);
            SP_FLAG:  sdo = 1'b0;
            SP_SHIFT: sdo = shreg[RES_W-1];
            default:  sdo = 1'b1;
        endcase
    end
endmodule

// File: rtl/wordrate_conv_seq.sv
module wordrate_conv_seq
    import wrc_pkg::*;
#(
    parameter int RES_W     = 24,
    parameter int PENALTY   = 7,
    parameter int FLAG_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       rate_code,
    input  logic             start_single,
    input  logic             start_cont,
    input  logic             power_save,
    input  logic             read_strobe,
    input  logic             pflag_mode,
    input  logic             sclk_pulse,
    input  logic [RES_W-1:0] data_in,
    output logic             eoc,
    output logic             done_flag,
    output logic [RES_W-1:0] result,
    output logic             sdo
);
    localparam int CNT_W = $clog2(WRC_MAX_PERIOD + PENALTY + 1);

    sq_state_t        st, st_nxt;
    logic [CNT_W-1:0] first_load, repeat_load, tmr_val;
    logic             tmr_load, tmr_run, tmr_zero;
    logic             start_any, complete, cont_q, flag_clr, sp_idle;

    assign start_any = start_single | start_cont;

    wrc_period_sel #(.CNT_W(CNT_W), .PENALTY(PENALTY)) u_sel (
        .rate_code  (rate_code),
        .first_load (first_load),
        .repeat_load(repeat_load)
    );

    wrc_down_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .run     (tmr_run),
        .at_zero (tmr_zero)
    );

    wrc_flag_port #(.RES_W(RES_W), .FLAG_CLKS(FLAG_CLKS)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .pflag_mode(pflag_mode),
        .done_flag (done_flag),
        .result    (result),
        .sclk_pulse(sclk_pulse),
        .sdo       (sdo),
        .flag_clr  (flag_clr),
        .port_idle (sp_idle)
    );

    // Next state and timer control.
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = first_load;
        tmr_run  = 1'b0;
        complete = 1'b0;
        if (power_save) begin
            st_nxt = SQ_SLEEP;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (start_any) begin
                        tmr_load = 1'b1;
                        st_nxt   = SQ_FIRST;
                    end
                end
                SQ_FIRST, SQ_REPEAT: begin
                    if (start_any) begin
                        tmr_load = 1'b1;
                        st_nxt   = SQ_FIRST;
                    end else if (tmr_zero) begin
                        complete = 1'b1;
                        if (cont_q) begin
                            tmr_load = 1'b1;
                            tmr_val  = repeat_load;
                            st_nxt   = SQ_REPEAT;
                        end else begin
                            st_nxt   = SQ_IDLE;
                        end
                    end else begin
                        tmr_run = 1'b1;
                    end
                end
                SQ_SLEEP: st_nxt = SQ_IDLE;
                default:  st_nxt = SQ_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nxt;
    end

    // Output and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc       <= 1'b0;
            done_flag <= 1'b0;
            result    <= '0;
            cont_q    <= 1'b0;
        end else begin
            eoc <= complete;
            if (complete) begin
                result    <= data_in;
                done_flag <= 1'b1;
            end else if (read_strobe || flag_clr) begin
                done_flag <= 1'b0;
            end
            if (!power_save && start_any) cont_q <= start_cont;
        end
    end
endmodule

// File: rtl/wordrate_conv_seq_chk.sv
module wordrate_conv_seq_chk #(
    parameter int RES_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             power_save,
    input logic             read_strobe,
    input logic             pflag_mode,
    input logic             sp_idle,
    input logic             eoc,
    input logic             done_flag,
    input logic [RES_W-1:0] result,
    input logic             sdo
);
    // R4
    eoc_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    // R4
    eoc_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> done_flag);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_strobe |=> (!done_flag || eoc));

    // R7
    sleep_no_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_save |=> !eoc);

    // R7
    sleep_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_save |=> $stable(result));

    // R8
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_flag) && pflag_mode && sp_idle) |-> !sdo);
endmodule

bind wordrate_conv_seq wordrate_conv_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_save (power_save),
    .read_strobe(read_strobe),
    .pflag_mode (pflag_mode),
    .sp_idle    (sp_idle),
    .eoc        (eoc),
    .done_flag  (done_flag),
    .result     (result),
    .sdo        (sdo)
);

// File: tb/wordrate_conv_seq_test.sv
module wordrate_conv_seq_test;
    localparam int RES_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       rate_code = 3'd0;
    logic             start_single = 1'b0, start_cont = 1'b0;
    logic             power_save = 1'b0, read_strobe = 1'b0;
    logic             pflag_mode = 1'b0, sclk_pulse = 1'b0;
    logic [RES_W-1:0] data_in = '0;
    logic             eoc, done_flag, sdo;
    logic [RES_W-1:0] result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wordrate_conv_seq #(.RES_W(RES_W)) uut (
        .clk(clk), .rst_n(rst_n), .rate_code(rate_code),
        .start_single(start_single), .start_cont(start_cont),
        .power_save(power_save), .read_strobe(read_strobe),
        .pflag_mode(pflag_mode), .sclk_pulse(sclk_pulse),
        .data_in(data_in), .eoc(eoc), .done_flag(done_flag),
        .result(result), .sdo(sdo)
    );

    function automatic int period_of(input int code);
        int tbl [8] = '{2182, 1090, 546, 266, 194, 162, 8722, 4362};
        return tbl[code];
    endfunction

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Strobe a start sampled at the next edge; returns at the negedge after it.
    task automatic pulse_start(input bit cont);
        @(negedge clk);
        if (cont) start_cont = 1'b1; else start_single = 1'b1;
        @(negedge clk);
        start_cont = 1'b0;
        start_single = 1'b0;
    endtask

    // Cycles until eoc is seen, counted from the last sampled strobe edge.
    task automatic wait_eoc(input int limit, output int k);
        k = 0;
        while (k <= limit) begin
            @(negedge clk);
            k++;
            if (eoc) break;
        end
    endtask

    task automatic count_eoc(input int cycles, output int n);
        n = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (eoc) n++;
        end
    endtask

    task automatic do_read;
        @(negedge clk);
        read_strobe = 1'b1;
        @(negedge clk);
        read_strobe = 1'b0;
    endtask

    task automatic sclk_tick;
        @(negedge clk);
        sclk_pulse = 1'b1;
        @(negedge clk);
        sclk_pulse = 1'b0;
    endtask

    task automatic stop_conv;
        @(negedge clk);
        power_save = 1'b1;
        @(negedge clk);
        @(negedge clk);
        power_save = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k, n, p;
        logic [RES_W-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10", "eoc", eoc, 0);
        chk("R10", "done_flag", done_flag, 0);
        chk("R10", "result", result, 0);
        chk("R10", "sdo", sdo, 1);

        // R1 R3 R4 single conversions on every rate code
        for (int c = 0; c < 8; c++) begin
            p = period_of(c);
            rate_code = 3'(c);
            data_in = RES_W'(c * 40961 + 17);
            pulse_start(1'b0);
            wait_eoc(p + 20, k);
            chk("R1", $sformatf("first period code %0d", c), k, p + 7);
            chk("R4", "result captured", result, c * 40961 + 17);
            chk("R4", "done set", done_flag, 1);
            count_eoc(p + 20, n);
            chk("R3", $sformatf("extra completions code %0d", c), n, 0);
            do_read;
            chk("R5", "read clears done", done_flag, 0);
        end

        // R1 R2 continuous conversions on every rate code
        for (int c = 0; c < 8; c++) begin
            p = period_of(c);
            rate_code = 3'(c);
            pulse_start(1'b1);
            wait_eoc(p + 20, k);
            chk("R1", $sformatf("cont first code %0d", c), k, p + 7);
            data_in = RES_W'(c + 100);
            wait_eoc(p + 20, k);
            chk("R2", $sformatf("cont second code %0d", c), k, p);
            data_in = RES_W'(c + 200);
            wait_eoc(p + 20, k);
            chk("R2", $sformatf("cont third code %0d", c), k, p);
            // R5 overwrite while flag still set
            chk("R5", "overwrite result", result, c + 200);
            chk("R5", "flag kept set", done_flag, 1);
            stop_conv;
            do_read;
        end

        // R3 both strobes together: continuous wins
        rate_code = 3'd5;
        @(negedge clk);
        start_single = 1'b1;
        start_cont = 1'b1;
        @(negedge clk);
        start_single = 1'b0;
        start_cont = 1'b0;
        wait_eoc(200, k);
        wait_eoc(200, k);
        chk("R3", "both strobes repeat", k, 162);
        stop_conv;
        do_read;

        // R6 restart during a conversion
        pulse_start(1'b0);
        repeat (49) @(negedge clk);
        pulse_start(1'b0);
        wait_eoc(250, k);
        chk("R6", "restart period", k, 169);
        do_read;

        // R5 read in the completion cycle: completion wins
        pulse_start(1'b0);
        repeat (168) @(negedge clk);
        read_strobe = 1'b1;
        @(negedge clk);
        read_strobe = 1'b0;
        chk("R5", "eoc at read cycle", eoc, 1);
        chk("R5", "done kept", done_flag, 1);
        do_read;

        // R7 power save halts and ignores starts
        rate_code = 3'd4;
        data_in = 24'h123456;
        pulse_start(1'b1);
        wait_eoc(250, k);
        held = result;
        repeat (30) @(negedge clk);
        power_save = 1'b1;
        repeat (10) @(negedge clk);
        pulse_start(1'b0);
        pulse_start(1'b1);
        data_in = 24'h654321;
        count_eoc(500, n);
        chk("R7", "no completions asleep", n, 0);
        chk("R7", "result held", result, held);
        chk("R7", "done held", done_flag, 1);
        power_save = 1'b0;
        count_eoc(300, n);
        chk("R7", "idle after wake", n, 0);
        pulse_start(1'b0);
        wait_eoc(250, k);
        chk("R7", "start after wake", k, 201);
        do_read;

        // R8 R9 ready-line handshake
        pflag_mode = 1'b1;
        rate_code = 3'd5;
        data_in = 24'hA5C396;
        @(negedge clk);
        chk("R8", "ready line high when empty", sdo, 1);
        pulse_start(1'b0);
        wait_eoc(250, k);
        chk("R8", "ready line low", sdo, 0);
        for (int t = 1; t < 8; t++) begin
            sclk_tick;
            chk("R9", $sformatf("ack clock %0d line low", t), sdo, 0);
        end
        chk("R9", "done before 8th clock", done_flag, 1);
        sclk_tick;
        chk("R9", "done cleared by 8th clock", done_flag, 0);
        chk("R9", "bit 23", sdo, 1);
        for (int b = 22; b >= 0; b--) begin
            sclk_tick;
            chk("R9", $sformatf("bit %0d", b), sdo, (24'hA5C396 >> b) & 1);
        end
        sclk_tick;
        chk("R9", "line idle high after word", sdo, 1);
        pflag_mode = 1'b0;
        pulse_start(1'b0);
        wait_eoc(250, k);
        chk("R8", "line high without ready mode", sdo, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule